// File: doc/BRIEF.md
# USB OUT Endpoint Receive Counter

This block keeps the byte count for one non-control USB endpoint and decides which received bytes reach the endpoint's packet SRAM. Firmware loads a count through a byte-wide register port. The low byte sits in one register, selected by `reg_sel` = 0. The remaining high count bit sits in bit 0 of a companion register, selected by `reg_sel` = 1. For IN traffic the block only presents this count to the transmitter on `tx_count`. For OUT traffic the same count acts as a receive limit.

The serial interface engine delivers the packet as a stream of `rx_valid`/`rx_byte` beats. It then raises a single `rx_eop` strobe in a cycle after the last byte, with `rx_valid` low. The last two bytes of every packet are its CRC. A byte whose 0-based position in the packet is below the limit is written to SRAM at `buf_base` plus that position. All other bytes are dropped.

At end of packet the block compares the total received length n (data plus CRC) with the limit L. If n ≥ 2 and n ≤ L + 2, the transaction completes: the count is overwritten with n and a completion pulse is raised. Otherwise the transaction is ignored: a separate pulse is raised and the count is left as it was. Firmware recovers the data length as the written-back count minus two.

Top module: `usb_ep_rx_counter`

## Requirements
- R1: While and right after reset, the count is 0, `busy` is 0, and `sram_we`, `xfer_done` and `xfer_ignored` are all low.
- R2: A register write with `reg_sel`=0 loads count bits 7:0 from `reg_wdata`. A write with `reg_sel`=1 loads count bit 8 from `reg_wdata[0]`. `reg_rdata` returns the selected part, zero-extended, and `tx_count` always shows the full 9-bit count.
- R3: `busy` rises after the first byte of a packet and falls after the `rx_eop` cycle. A register write is discarded if it arrives while `busy` is high, or in a cycle with `rx_valid` or `rx_eop` high.
- R4: A stored byte at packet position i appears on `sram_wdata` with `sram_we` high one cycle after it was received. Its address is `buf_base` + i, modulo the address range.
- R5: A byte is stored exactly when its position is below the count. When the count is at least the total length, all data bytes and both CRC bytes are stored.
- R6: When the data length equals the count, only the data bytes are stored and the transaction completes.
- R7: When the count is exactly one more than the data length, bytes are stored up to the count (the first CRC byte included) and the transaction completes.
- R8: When the data length exceeds the count, `xfer_ignored` pulses, `xfer_done` stays low, and the count keeps its value. No byte at a position at or above the count is stored.
- R9: On completion, `xfer_done` pulses for one cycle after the `rx_eop` cycle. In that same cycle `tx_count` equals the total received length (data length plus two).
- R10: An end of packet after fewer than two bytes is ignored.
- R11: Each end-of-packet produces exactly one of `xfer_done` or `xfer_ignored`, never both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: low count byte, 1: high count bit register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_eop | input | 1 | End of packet strobe, in a cycle without a byte |
| buf_base | input | 9 | SRAM base address of this endpoint's buffer |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 9 | SRAM write address |
| sram_wdata | output | 8 | SRAM write data |
| xfer_done | output | 1 | OUT transaction completed pulse |
| xfer_ignored | output | 1 | OUT transaction ignored pulse |
| busy | output | 1 | Packet reception in progress |
| tx_count | output | 9 | Current count, used as IN byte count |

## Verification
The assertions check, on every cycle, the invariants that hold regardless of the packet:
- completion and ignore pulses never coincide;
- writes occur only while busy and stay below the count the packet started with;
- back-to-back writes step the address by one;
- an ignore leaves the count untouched;
- a completion leaves a count of at least two.

Which of the length cases (full, exact, partial, overflow, runt) applies, how many bytes each one stores, and that register writes are blocked mid-packet can only be shown by the bench scenarios. These are compared against the bench's behavioural model cycle by cycle.

// File: rtl/usb_rxc_pkg.sv
package usb_rxc_pkg;

   typedef enum logic [1:0] {
      RXC_NONE   = 2'd0,
      RXC_DONE   = 2'd1,
      RXC_IGNORE = 2'd2
   } rxc_outcome_e;

   localparam int RXC_CRC_BYTES = 2;

endpackage

// File: rtl/usb_rxc_regs.sv
module usb_rxc_regs #(
   parameter int CNT_W = 9,
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             wb_en,
   input  logic [CNT_W-1:0] wb_value,
   input  logic             rd_sel,
   output logic [REG_W-1:0] rd_data,
   output logic [CNT_W-1:0] count
);
   localparam int HI_W = CNT_W - REG_W;

   logic [REG_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else if (wb_en) begin
         lo_q <= wb_value[REG_W-1:0];
      end else if (wr_en && !wr_sel) begin
         lo_q <= wr_data;
      end
   end

   generate
      if (HI_W > 0) begin : g_split
         logic [HI_W-1:0] hi_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q <= '0;
            end else if (wb_en) begin
               hi_q <= wb_value[CNT_W-1:REG_W];
            end else if (wr_en && wr_sel) begin
               hi_q <= wr_data[HI_W-1:0];
            end
         end

         assign count   = {hi_q, lo_q};
         assign rd_data = rd_sel ? {{(REG_W-HI_W){1'b0}}, hi_q} : lo_q;
      end else begin : g_single
         assign count   = lo_q;
         assign rd_data = rd_sel ? '0 : lo_q;
      end
   endgenerate

endmodule

// File: rtl/usb_rxc_track.sv
module usb_rxc_track
   import usb_rxc_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_eop,
   input  logic [CNT_W-1:0] limit,
   output logic             busy,
   output logic [CNT_W:0]   byte_idx,
   output logic             store_ok,
   output logic             wb_en,
   output logic [CNT_W-1:0] wb_value,
   output rxc_outcome_e     outcome
);
   localparam int N_W  = CNT_W + 1;
   localparam int CMP_W = CNT_W + 2;
   localparam logic [N_W-1:0] N_MAX = '1;

   logic [N_W-1:0]   n_q;
   logic             busy_q;
   rxc_outcome_e     outcome_q;
   logic [CMP_W-1:0] lim_ext;
   logic [CMP_W-1:0] n_ext;
   logic             accept;

   assign lim_ext  = CMP_W'(limit) + CMP_W'(RXC_CRC_BYTES);
   assign n_ext    = CMP_W'(n_q);
   assign accept   = (n_ext >= CMP_W'(RXC_CRC_BYTES)) && (n_ext <= lim_ext);
   assign store_ok = rx_valid && !rx_eop && (n_q < N_W'(limit));
   assign wb_en    = rx_eop && accept;
   assign wb_value = n_q[CNT_W-1:0];
   assign byte_idx = n_q;
   assign busy     = busy_q;
   assign outcome  = outcome_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q       <= '0;
         busy_q    <= 1'b0;
         outcome_q <= RXC_NONE;
      end else if (rx_eop) begin
         n_q       <= '0;
         busy_q    <= 1'b0;
         outcome_q <= accept ? RXC_DONE : RXC_IGNORE;
      end else begin
         outcome_q <= RXC_NONE;
         if (rx_valid) begin
            busy_q <= 1'b1;
            if (n_q != N_MAX) begin
               n_q <= n_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/usb_rxc_wr.sv
module usb_rxc_wr #(
   parameter int ADDR_W = 9,
   parameter int IDX_W  = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_ok,
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [ADDR_W-1:0] base,
   input  logic [DATA_W-1:0] data,
   output logic              we,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);
   logic [ADDR_W-1:0] next_addr;

   assign next_addr = base + ADDR_W'(byte_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we    <= 1'b0;
         addr  <= '0;
         wdata <= '0;
      end else begin
         we <= store_ok;
         if (store_ok) begin
            addr  <= next_addr;
            wdata <= data;
         end
      end
   end

endmodule

// File: rtl/usb_ep_rx_counter.sv
module usb_ep_rx_counter
   import usb_rxc_pkg::*;
#(
   parameter int CNT_W  = 9,
   parameter int REG_W  = 8,
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              rx_valid,
   input  logic [REG_W-1:0]  rx_byte,
   input  logic              rx_eop,
   input  logic [ADDR_W-1:0] buf_base,
   output logic              sram_we,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [REG_W-1:0]  sram_wdata,
   output logic              xfer_done,
   output logic              xfer_ignored,
   output logic              busy,
   output logic [CNT_W-1:0]  tx_count
);
   localparam int IDX_W = CNT_W + 1;

   generate
      if (CNT_W < REG_W) begin : g_chk_narrow
         $error("count must be at least one register wide");
      end
      if (CNT_W >= 2 * REG_W) begin : g_chk_wide
         $error("count must fit in two registers");
      end
      if (ADDR_W < 2) begin : g_chk_addr
         $error("address too narrow");
      end
   endgenerate

   logic             reg_wr_ok;
   logic             wb_en;
   logic [CNT_W-1:0] wb_value;
   logic [CNT_W-1:0] count;
   logic [IDX_W-1:0] byte_idx;
   logic             store_ok;
   rxc_outcome_e     outcome;

   assign reg_wr_ok = reg_wr && !busy && !rx_valid && !rx_eop;

   usb_rxc_regs #(
      .CNT_W (CNT_W),
      .REG_W (REG_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_ok),
      .wr_sel   (reg_sel),
      .wr_data  (reg_wdata),
      .wb_en    (wb_en),
      .wb_value (wb_value),
      .rd_sel   (reg_sel),
      .rd_data  (reg_rdata),
      .count    (count)
   );

   usb_rxc_track #(
      .CNT_W (CNT_W)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_eop   (rx_eop),
      .limit    (count),
      .busy     (busy),
      .byte_idx (byte_idx),
      .store_ok (store_ok),
      .wb_en    (wb_en),
      .wb_value (wb_value),
      .outcome  (outcome)
   );

   usb_rxc_wr #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .DATA_W (REG_W)
   ) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .store_ok (store_ok),
      .byte_idx (byte_idx),
      .base     (buf_base),
      .data     (rx_byte),
      .we       (sram_we),
      .addr     (sram_addr),
      .wdata    (sram_wdata)
   );

   assign tx_count     = count;
   assign xfer_done    = (outcome == RXC_DONE);
   assign xfer_ignored = (outcome == RXC_IGNORE);

endmodule

// File: rtl/usb_ep_rx_counter_chk.sv
module usb_ep_rx_counter_chk #(
   parameter int CNT_W  = 9,
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] buf_base,
   input logic              sram_we,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              xfer_done,
   input logic              xfer_ignored,
   input logic              busy,
   input logic [CNT_W-1:0]  tx_count
);
   logic [ADDR_W-1:0] base_d;
   logic [CNT_W-1:0]  cnt_d;
   logic [ADDR_W-1:0] offset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_d <= '0;
         cnt_d  <= '0;
      end else begin
         base_d <= buf_base;
         cnt_d  <= tx_count;
      end
   end

   assign offset = sram_addr - base_d;

   assert_done_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer_done && xfer_ignored));

   assert_wr_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we |-> busy);

   assert_wr_below_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we |-> (int'(offset) < int'(cnt_d)));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_we && $past(sram_we)) |-> (sram_addr == ADDR_W'($past(sram_addr) + 1'b1)));

   assert_ign_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ignored |-> $stable(tx_count));

   assert_done_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (int'(tx_count) >= 2));

endmodule

bind usb_ep_rx_counter usb_ep_rx_counter_chk #(
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .buf_base     (buf_base),
   .sram_we      (sram_we),
   .sram_addr    (sram_addr),
   .xfer_done    (xfer_done),
   .xfer_ignored (xfer_ignored),
   .busy         (busy),
   .tx_count     (tx_count)
);

// File: tb/usb_ep_rx_counter_bench.sv
`timescale 1ns/1ps
module usb_ep_rx_counter_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_eop = 1'b0;
   logic [8:0] buf_base = 9'h040;
   logic       sram_we;
   logic [8:0] sram_addr;
   logic [7:0] sram_wdata;
   logic       xfer_done;
   logic       xfer_ignored;
   logic       busy;
   logic [8:0] tx_count;

   int checks = 0;
   int errors = 0;
   int wr_tally = 0, done_tally = 0, ign_tally = 0;

   int m_cnt = 0, m_n = 0, m_addr = 0, m_data = 0;
   bit m_busy = 0, m_we = 0, m_done = 0, m_ign = 0;

   always #2.5 clk = ~clk;

   usb_ep_rx_counter u_usb_ep_rx_counter (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .rx_eop(rx_eop), .buf_base(buf_base),
      .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
      .xfer_done(xfer_done), .xfer_ignored(xfer_ignored), .busy(busy),
      .tx_count(tx_count));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model, evaluated at each rising edge
   always @(posedge clk) begin : model
      bit blocked;
      int lim;
      if (!rst_n) begin
         m_cnt = 0; m_n = 0; m_busy = 0; m_we = 0; m_done = 0; m_ign = 0;
      end else begin
         lim = m_cnt;
         blocked = m_busy || rx_valid || rx_eop;
         m_we = 0; m_done = 0; m_ign = 0;
         if (rx_eop) begin
            if (m_n < 2 || m_n > lim + 2) m_ign = 1;
            else begin m_done = 1; m_cnt = m_n % 512; end
            m_n = 0; m_busy = 0;
         end else if (rx_valid) begin
            if (m_n < lim) begin
               m_we = 1; m_addr = (int'(buf_base) + m_n) % 512; m_data = int'(rx_byte);
            end
            if (m_n < 1023) m_n++;
            m_busy = 1;
         end
         if (reg_wr && !blocked) begin
            if (!reg_sel) m_cnt = (m_cnt & 256) | int'(reg_wdata);
            else m_cnt = (m_cnt & 255) | (int'(reg_wdata[0]) << 8);
         end
      end
   end

   // compare against the model away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(sram_we == m_we, "R5 write enable", int'(sram_we), int'(m_we));
         if (m_we) begin
            check(int'(sram_addr) == m_addr, "R4 address", int'(sram_addr), m_addr);
            check(int'(sram_wdata) == m_data, "R4 data", int'(sram_wdata), m_data);
         end
         check(xfer_done == m_done, "R9 done pulse", int'(xfer_done), int'(m_done));
         check(xfer_ignored == m_ign, "R8 ignore pulse", int'(xfer_ignored), int'(m_ign));
         check(int'(tx_count) == m_cnt, "R2 count", int'(tx_count), m_cnt);
         check(busy == m_busy, "R3 busy", int'(busy), int'(m_busy));
         check(int'(reg_rdata) == (reg_sel ? (m_cnt >> 8) : (m_cnt & 255)),
               "R2 readback", int'(reg_rdata), reg_sel ? (m_cnt >> 8) : (m_cnt & 255));
         if (sram_we) wr_tally++;
         if (xfer_done) done_tally++;
         if (xfer_ignored) ign_tally++;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_count(input int v);
      reg_wr = 1; reg_sel = 0; reg_wdata = 8'(v & 255); tick();
      reg_sel = 1; reg_wdata = 8'(v >> 8); tick();
      reg_wr = 0; reg_sel = 0; tick();
   endtask

   task automatic send_packet(input int nbytes, input bit gaps, input bit poke);
      for (int i = 0; i < nbytes; i++) begin
         rx_valid = 1; rx_byte = 8'((i * 37 + nbytes) & 255);
         if (poke) begin reg_wr = 1; reg_sel = 0; reg_wdata = 8'h55; end
         tick();
         if (gaps && (i % 2 == 1)) begin rx_valid = 0; tick(); end
      end
      rx_valid = 0; rx_eop = 1; tick();
      rx_eop = 0; reg_wr = 0; tick(); tick(); tick();
   endtask

   task automatic run_case(input string req, input int lim, input int nbytes, input bit gaps,
                           input bit poke, input int exp_wr, input bit exp_done);
      set_count(lim);
      wr_tally = 0; done_tally = 0; ign_tally = 0;
      send_packet(nbytes, gaps, poke);
      check(wr_tally == exp_wr, {req, " stored bytes"}, wr_tally, exp_wr);
      check(done_tally == int'(exp_done), {req, " completion"}, done_tally, int'(exp_done));
      check(ign_tally == int'(!exp_done), {req, " ignore"}, ign_tally, int'(!exp_done));
      check(done_tally + ign_tally == 1, "R11 one outcome", done_tally + ign_tally, 1);
      check(int'(tx_count) == (exp_done ? nbytes : lim), {req, " final count"},
            int'(tx_count), exp_done ? nbytes : lim);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stimulus
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(tx_count == 0, "R1 count", int'(tx_count), 0);
      check(!sram_we && !xfer_done && !xfer_ignored, "R1 outputs",
            int'({sram_we, xfer_done, xfer_ignored}), 0);
      check(!busy, "R1 busy", int'(busy), 0);
      @(posedge clk); #1; rst_n = 1; tick();

      // R2: register halves
      reg_wr = 1; reg_sel = 0; reg_wdata = 8'h34; tick();
      reg_sel = 1; reg_wdata = 8'h01; tick();
      reg_wr = 0; tick();
      check(tx_count == 9'h134, "R2 composed count", int'(tx_count), 'h134);
      reg_sel = 0; #1;
      check(reg_rdata == 8'h34, "R2 low readback", int'(reg_rdata), 'h34);

      run_case("R5 roomy", 8, 6, 0, 0, 6, 1);
      run_case("R5 count equals total", 6, 6, 0, 0, 6, 1);
      run_case("R6 exact", 4, 6, 0, 0, 4, 1);
      run_case("R7 partial", 5, 6, 0, 0, 5, 1);
      run_case("R8 overflow", 3, 6, 0, 0, 3, 0);
      run_case("R10 runt", 4, 1, 0, 0, 1, 0);
      run_case("R9 zero length", 0, 2, 0, 0, 0, 1);
      run_case("R9 largest", 256, 258, 0, 0, 256, 1);
      buf_base = 9'h1FC;
      run_case("R4 wrap with gaps", 10, 8, 1, 0, 8, 1);
      buf_base = 9'h040;
      run_case("R3 blocked write", 20, 6, 0, 1, 6, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule